// File: doc/BRIEF.md
# Lockable message transmit buffer

This block is a small message store that sits between a host CPU port and a serial transmit engine. It holds one outgoing frame of ten bytes. Byte 0 is the identifier, byte 1 is the control byte, and bytes 2 to 9 carry up to eight data bytes. All ten bytes live in a single-ported store, so only one side can use it at any time.

An ownership flag decides which side that is. While the buffer is released, the CPU may write and read it freely. A transmit request takes the lock. The engine is then told, by a one-cycle pulse, that a frame is ready. From that point only the engine may read the store. The lock is given back when the engine reports either that the transfer completed or that it was aborted.

The engine read path uses valid/ready. The engine holds `eng_rd_valid` and `eng_addr` until it sees `eng_rd_ready` high on a clock edge. Ready is high exactly while the buffer is locked. The read data comes back one cycle after the accepted request, flagged by `eng_rsp_valid`. The response cannot be stalled, so the engine must take it in that cycle. CPU accesses are single-cycle strobes with no back-pressure. A CPU read answers one cycle later on `cpu_rvalid`/`cpu_rdata`.

Top module: `msg_tx_buffer`

## Requirements
- R1: After reset, `buf_locked`, `frame_ready`, `cpu_rvalid` and `eng_rsp_valid` are all 0.
- R2: While released, a CPU write stores `cpu_wdata` at `cpu_addr`. A CPU read returns the stored byte with `cpu_rvalid` high in the next cycle. The layout is identifier at address 0, control at address 1, and data at addresses 2 to 9. If write and read are strobed together, the write is done and no read response follows.
- R3: A `tx_req` seen while released sets `buf_locked` in the next cycle. `frame_ready` is high for exactly that one cycle.
- R4: A CPU write attempted while locked leaves the stored byte unchanged.
- R5: A CPU read attempted while locked still gives `cpu_rvalid` in the next cycle, but with `cpu_rdata` equal to 0.
- R6: `eng_rd_ready` equals `buf_locked`. An engine read accepted while locked returns the stored byte with `eng_rsp_valid` in the next cycle. An engine request while released gets no response.
- R7: `eng_done` while locked clears `buf_locked` in the next cycle.
- R8: `eng_abort` while locked clears `buf_locked` in the next cycle.
- R9: A `tx_req` while already locked is ignored. The buffer stays locked and no further `frame_ready` pulse is produced.
- R10: Addresses 10 and above are outside the store. Writes to them are ignored, and reads from either port return 0 with the usual valid.
- R11: `eng_done` or `eng_abort` while released has no effect. The buffer stays released and `frame_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_addr | input | AW (4) | CPU byte address |
| cpu_wdata | input | DW (8) | CPU write data |
| cpu_rdata | output | DW (8) | CPU read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | CPU read response strobe |
| tx_req | input | 1 | Transmit request, takes the lock |
| buf_locked | output | 1 | 1 = engine owns the buffer |
| frame_ready | output | 1 | One-cycle pulse when the lock is taken |
| eng_rd_valid | input | 1 | Engine read request valid |
| eng_rd_ready | output | 1 | Engine read request accepted |
| eng_addr | input | AW (4) | Engine byte address |
| eng_rdata | output | DW (8) | Engine read data, valid with eng_rsp_valid |
| eng_rsp_valid | output | 1 | Engine read response strobe |
| eng_done | input | 1 | Engine reports transfer complete |
| eng_abort | input | 1 | Engine reports transfer aborted |

## Verification
The bench builds the block with its default parameters: ten bytes of eight bits, which gives a four-bit address. That leaves addresses 10 to 15 reachable from both ports, so the out-of-range rules can be driven directly. Each ownership change, including repeated requests and stray completion or abort signals while released, is driven in its own directed scenario. The stored bytes are read back afterwards to show what a locked write did or did not change.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  typedef enum logic {
    OWN_CPU    = 1'b0,
    OWN_ENGINE = 1'b1
  } owner_e;

  localparam int unsigned IDX_IDENT = 0;
  localparam int unsigned IDX_CTRL  = 1;
  localparam int unsigned IDX_DATA0 = 2;
endpackage

// File: rtl/txbuf_store.sv
module txbuf_store #(
  parameter int unsigned NBYTES = 10,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NBYTES];

  // single port: one address per cycle, registered read
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end else if (re) begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/txbuf_lock.sv
module txbuf_lock
  import txbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic eng_done,
  input  logic eng_abort,
  output logic locked,
  output logic frame_ready
);
  owner_e owner_q, owner_d;
  logic   take;

  assign take = (owner_q == OWN_CPU) && tx_req;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_CPU:    if (tx_req) owner_d = OWN_ENGINE;
      OWN_ENGINE: if (eng_done || eng_abort) owner_d = OWN_CPU;
      default:    owner_d = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q     <= OWN_CPU;
      frame_ready <= 1'b0;
    end else begin
      owner_q     <= owner_d;
      frame_ready <= take;
    end
  end

  assign locked = (owner_q == OWN_ENGINE);

  p_lock_on_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && tx_req |=> locked && frame_ready);
  p_ready_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> !frame_ready);
  p_release_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && eng_done |=> !locked);
  p_release_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked && eng_abort |=> !locked);
  p_req_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked && tx_req && !eng_done && !eng_abort |=> locked && !frame_ready);
  p_stray_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && !tx_req |=> !locked && !frame_ready);
endmodule

// File: rtl/txbuf_portmux.sv
module txbuf_portmux #(
  parameter int unsigned NBYTES = 10,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          locked,
  input  logic          cpu_wr_en,
  input  logic          cpu_rd_en,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rvalid,
  input  logic          eng_rd_valid,
  output logic          eng_rd_ready,
  input  logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_rdata,
  output logic          eng_rsp_valid,
  output logic          st_we,
  output logic          st_re,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_wdata,
  input  logic [DW-1:0] st_rdata
);
  localparam logic [AW:0] LIMIT = (AW+1)'(NBYTES);

  logic cpu_in_range, eng_in_range;
  logic cpu_rd_go, eng_rd_go;
  logic cpu_hit_q, eng_hit_q;

  assign cpu_in_range = ({1'b0, cpu_addr} < LIMIT);
  assign eng_in_range = ({1'b0, eng_addr} < LIMIT);
  assign eng_rd_ready = locked;

  assign cpu_rd_go = cpu_rd_en && !cpu_wr_en;
  assign eng_rd_go = eng_rd_valid && locked;

  always_comb begin
    st_we    = 1'b0;
    st_re    = 1'b0;
    st_addr  = cpu_addr;
    st_wdata = cpu_wdata;
    if (locked) begin
      st_addr = eng_addr;
      st_re   = eng_rd_go && eng_in_range;
    end else begin
      st_we = cpu_wr_en && cpu_in_range;
      st_re = cpu_rd_go && cpu_in_range;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rvalid    <= 1'b0;
      cpu_hit_q     <= 1'b0;
      eng_rsp_valid <= 1'b0;
      eng_hit_q     <= 1'b0;
    end else begin
      cpu_rvalid    <= cpu_rd_go;
      cpu_hit_q     <= cpu_rd_go && !locked && cpu_in_range;
      eng_rsp_valid <= eng_rd_go;
      eng_hit_q     <= eng_rd_go && eng_in_range;
    end
  end

  assign cpu_rdata = cpu_hit_q ? st_rdata : '0;
  assign eng_rdata = eng_hit_q ? st_rdata : '0;

  p_no_write_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !st_we);
  p_zero_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked && cpu_rd_en && !cpu_wr_en |=> cpu_rvalid && (cpu_rdata == '0));
  p_eng_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !eng_rsp_valid);
  p_eng_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked && eng_rd_valid |=> eng_rsp_valid);
  p_range_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rd_go && !eng_in_range |=> eng_rdata == '0);
endmodule

// File: rtl/msg_tx_buffer.sv
module msg_tx_buffer #(
  parameter int unsigned NBYTES = 10,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr_en,
  input  logic          cpu_rd_en,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rvalid,
  input  logic          tx_req,
  output logic          buf_locked,
  output logic          frame_ready,
  input  logic          eng_rd_valid,
  output logic          eng_rd_ready,
  input  logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_rdata,
  output logic          eng_rsp_valid,
  input  logic          eng_done,
  input  logic          eng_abort
);
  logic          st_we, st_re;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_wdata, st_rdata;

  txbuf_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_req      (tx_req),
    .eng_done    (eng_done),
    .eng_abort   (eng_abort),
    .locked      (buf_locked),
    .frame_ready (frame_ready)
  );

  txbuf_portmux #(.NBYTES(NBYTES), .DW(DW), .AW(AW)) u_mux (
    .clk           (clk),
    .rst_n         (rst_n),
    .locked        (buf_locked),
    .cpu_wr_en     (cpu_wr_en),
    .cpu_rd_en     (cpu_rd_en),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_rdata     (cpu_rdata),
    .cpu_rvalid    (cpu_rvalid),
    .eng_rd_valid  (eng_rd_valid),
    .eng_rd_ready  (eng_rd_ready),
    .eng_addr      (eng_addr),
    .eng_rdata     (eng_rdata),
    .eng_rsp_valid (eng_rsp_valid),
    .st_we         (st_we),
    .st_re         (st_re),
    .st_addr       (st_addr),
    .st_wdata      (st_wdata),
    .st_rdata      (st_rdata)
  );

  txbuf_store #(.NBYTES(NBYTES), .DW(DW), .AW(AW)) u_store (
    .clk   (clk),
    .we    (st_we),
    .re    (st_re),
    .addr  (st_addr),
    .wdata (st_wdata),
    .rdata (st_rdata)
  );

  p_ready_tracks_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rd_ready == buf_locked);
  p_cpu_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_en && !cpu_wr_en |=> cpu_rvalid);
endmodule

// File: tb/tb_msg_tx_buffer.sv
`timescale 1ns/1ps
module tb_msg_tx_buffer;
  localparam int NB = 10;
  localparam int DW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_wr_en, cpu_rd_en;
  logic [AW-1:0] cpu_addr, eng_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, eng_rdata;
  logic cpu_rvalid, tx_req, buf_locked, frame_ready;
  logic eng_rd_valid, eng_rd_ready, eng_rsp_valid, eng_done, eng_abort;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [NB];

  always #10 clk = ~clk;

  msg_tx_buffer #(.NBYTES(NB), .DW(DW), .AW(AW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_wr_en = 0; cpu_rd_en = 0; cpu_addr = '0; cpu_wdata = '0;
    tx_req = 0; eng_rd_valid = 0; eng_addr = '0; eng_done = 0; eng_abort = 0;
  endtask

  task automatic cpu_write(input int a, input int d);
    @(negedge clk);
    cpu_wr_en = 1; cpu_addr = AW'(a); cpu_wdata = DW'(d);
    @(negedge clk);
    cpu_wr_en = 0;
  endtask

  task automatic cpu_read(input int a, output int d, output bit v);
    @(negedge clk);
    cpu_rd_en = 1; cpu_addr = AW'(a);
    @(posedge clk); #1;
    d = int'(cpu_rdata); v = cpu_rvalid;
    @(negedge clk);
    cpu_rd_en = 0;
  endtask

  task automatic eng_read(input int a, output int d, output bit v);
    @(negedge clk);
    eng_rd_valid = 1; eng_addr = AW'(a);
    @(posedge clk); #1;
    d = int'(eng_rdata); v = eng_rsp_valid;
    @(negedge clk);
    eng_rd_valid = 0;
  endtask

  task automatic take_lock(input string tag);
    @(negedge clk);
    tx_req = 1;
    @(posedge clk); #1;
    chk(buf_locked && frame_ready, tag, {buf_locked, frame_ready}, 3);
    @(negedge clk);
    tx_req = 0;
    @(posedge clk); #1;
    chk(buf_locked && !frame_ready, {tag, " pulse one cycle"}, {buf_locked, frame_ready}, 2);
  endtask

  task automatic t_reset();
    chk(!buf_locked && !frame_ready && !cpu_rvalid && !eng_rsp_valid, "R1 reset state",
        {buf_locked, frame_ready, cpu_rvalid, eng_rsp_valid}, 0);
  endtask

  task automatic t_cpu_fill();
    int d; bit v; bit ok = 1;
    for (int i = 0; i < NB; i++) begin
      model[i] = DW'(8'h40 + 7 * i);
      cpu_write(i, model[i]);
    end
    for (int i = 0; i < NB; i++) begin
      cpu_read(i, d, v);
      if (!v || d != int'(model[i])) begin
        ok = 0;
        chk(0, "R2 cpu readback", d, model[i]);
      end
    end
    chk(ok, "R2 cpu readback all bytes", 0, 0);
    // write and read strobed together: write done, no response
    @(negedge clk);
    cpu_wr_en = 1; cpu_rd_en = 1; cpu_addr = 4'd3; cpu_wdata = 8'hA7;
    @(posedge clk); #1;
    chk(!cpu_rvalid, "R2 write wins over read", cpu_rvalid, 0);
    @(negedge clk);
    cpu_wr_en = 0; cpu_rd_en = 0;
    model[3] = 8'hA7;
    cpu_read(3, d, v);
    chk(v && d == 'hA7, "R2 simultaneous write stored", d, 'hA7);
  endtask

  task automatic t_range();
    int d; bit v;
    cpu_write(12, 'h99);
    cpu_read(12, d, v);
    chk(v && d == 0, "R10 cpu out of range", d, 0);
    cpu_read(15, d, v);
    chk(v && d == 0, "R10 cpu addr 15", d, 0);
  endtask

  task automatic t_eng_released();
    int d; bit v;
    @(negedge clk);
    chk(!eng_rd_ready, "R6 ready low while released", eng_rd_ready, 0);
    eng_read(0, d, v);
    chk(!v, "R6 no response while released", v, 0);
  endtask

  task automatic t_locked_ops();
    int d; bit v; bit ok = 1;
    take_lock("R3 lock on request");
    chk(eng_rd_ready, "R6 ready high while locked", eng_rd_ready, 1);
    cpu_write(2, 'hEE);
    cpu_read(0, d, v);
    chk(v && d == 0, "R5 cpu read while locked", d, 0);
    for (int i = 0; i < NB; i++) begin
      eng_read(i, d, v);
      if (!v || d != int'(model[i])) begin
        ok = 0;
        chk(0, "R6 engine read", d, model[i]);
      end
    end
    chk(ok, "R6 engine reads all bytes", 0, 0);
    eng_read(11, d, v);
    chk(v && d == 0, "R10 engine out of range", d, 0);
    // second request while locked
    @(negedge clk);
    tx_req = 1;
    @(posedge clk); #1;
    chk(buf_locked && !frame_ready, "R9 request while locked", {buf_locked, frame_ready}, 2);
    @(negedge clk);
    tx_req = 0;
    eng_done = 1;
    @(posedge clk); #1;
    chk(!buf_locked, "R7 done releases", buf_locked, 0);
    @(negedge clk);
    eng_done = 0;
    cpu_read(2, d, v);
    chk(v && d == int'(model[2]), "R4 locked write ignored", d, model[2]);
  endtask

  task automatic t_abort();
    take_lock("R3 relock");
    @(negedge clk);
    eng_abort = 1;
    @(posedge clk); #1;
    chk(!buf_locked, "R8 abort releases", buf_locked, 0);
    @(negedge clk);
    eng_abort = 0;
  endtask

  task automatic t_stray();
    int d; bit v;
    @(negedge clk);
    eng_done = 1; eng_abort = 1;
    @(posedge clk); #1;
    chk(!buf_locked && !frame_ready, "R11 stray end while released",
        {buf_locked, frame_ready}, 0);
    @(negedge clk);
    eng_done = 0; eng_abort = 0;
    cpu_write(0, 'h3C);
    cpu_read(0, d, v);
    chk(v && d == 'h3C, "R11 cpu still owns buffer", d, 'h3C);
  endtask

  bit finished = 0;

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_cpu_fill();
    t_range();
    t_eng_released();
    t_locked_ops();
    t_abort();
    t_stray();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule